// File: doc/BRIEF.md
# Two's Complement Add/Subtract/Negate Unit

A purely combinational arithmetic block for `W`-bit two's-complement integers (default `W` = 8). An operation code picks one of four functions on operands `op_a` and `op_b`: add, subtract, negate `op_a`, or widen `op_a` to `2W` bits with its sign. The narrow result, the adder's raw carry and a signed overflow flag are valid in the same cycle as the inputs.

All four functions share one adder. It sees a first operand (`op_a` or zero) and a second operand (`op_b`, its inverse, the inverse of `op_a`, or zero), plus a carry-in. Subtraction adds the inverted subtrahend with a carry-in of one. Negation adds the inverted `op_a` to zero with a carry-in of one. The wide output is always the narrow result extended with its sign, so a client of widening reads it directly. The representable range is -2^(W-1) to 2^(W-1)-1, and zero has one encoding.

Top module: `twos_arith_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `res` equals (`op_a` + `op_b`) mod 2^W, and the carry past the top bit is dropped from `res`.
- R2: With `op_sel` = 2'b01 (subtract), `res` equals `op_a` + ~`op_b` + 1 mod 2^W, which is `op_a` - `op_b` mod 2^W.
- R3: For add, `ovf` is 1 exactly when `op_a` and `op_b` have equal sign bits (bit W-1) and the sign bit of `res` differs from them.
- R4: For subtract, `ovf` is 1 exactly when the sign bits of `op_a` and ~`op_b` are equal and the sign bit of `res` differs from that of `op_a`.
- R5: With `op_sel` = 2'b10 (negate), `res` equals ~`op_a` + 1 mod 2^W. Negating zero gives zero with `carry_out` = 1 and `ovf` = 0.
- R6: When negating the most negative value (only bit W-1 set), `res` returns that same pattern and `ovf` = 1. Every other negate gives `ovf` = 0.
- R7: With `op_sel` = 2'b11 (sign-extend), `res` equals `op_a`, the upper W bits of `res_wide` are all copies of bit W-1 of `op_a`, and `ovf` = 0.
- R8: `carry_out` is bit W of the shared adder's sum for every operation, independent of `ovf`. For add this is bit W of `op_a`+`op_b`. For subtract it is bit W of `op_a`+~`op_b`+1. For negate it is bit W of ~`op_a`+1. For sign-extend it is 0.
- R9: `res_wide` always equals `res` sign-extended to 2W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand; the source for negate and sign-extend |
| op_b | input | W | Second operand; the addend or subtrahend |
| op_sel | input | 2 | 00 add, 01 subtract, 10 negate, 11 sign-extend |
| res | output | W | Narrow result |
| res_wide | output | 2W | `res` sign-extended to twice the width |
| carry_out | output | 1 | Raw carry out of the shared adder |
| ovf | output | 1 | Signed overflow |

## Verification
The bench builds two copies of the unit, one with W = 8 and one with W = 4. The 4-bit copy is driven with every combination of operands and operation codes, so every overflow boundary, both zero-negation and most-negative-negation cases and every carry pattern are covered. The 8-bit copy receives directed corners at the edges of its range (0, 1, -1, 127, -128) followed by several thousand random vectors.

// File: rtl/twos_arith_unit.sv
module twos_arith_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [1:0]     op_sel,
  output logic [W-1:0]   res,
  output logic [2*W-1:0] res_wide,
  output logic           carry_out,
  output logic           ovf
);

  localparam logic [1:0]   OP_ADD   = 2'b00;
  localparam logic [1:0]   OP_SUB   = 2'b01;
  localparam logic [1:0]   OP_NEG   = 2'b10;
  localparam logic [1:0]   OP_EXT   = 2'b11;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_cin;
  logic [W:0]   add_sum;

  // operand steering onto the single adder (R10 encoding: 00 add, 01 sub, 10 neg, 11 ext)
  always_comb begin
    case (op_sel)
      OP_ADD:  begin add_x = op_a;     add_y = op_b;     add_cin = 1'b0; end
      OP_SUB:  begin add_x = op_a;     add_y = ~op_b;    add_cin = 1'b1; end
      OP_NEG:  begin add_x = '0;       add_y = ~op_a;    add_cin = 1'b1; end
      default: begin add_x = op_a;     add_y = '0;       add_cin = 1'b0; end
    endcase
  end

  assign add_sum   = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
  assign res       = add_sum[W-1:0];
  assign carry_out = add_sum[W];
  assign res_wide  = {{W{res[W-1]}}, res};

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: ovf = (add_x[W-1] == add_y[W-1]) && (res[W-1] != add_x[W-1]);
      OP_NEG:         ovf = (op_a != '0) && (res[W-1] == op_a[W-1]);
      default:        ovf = 1'b0;
    endcase
  end

  // reference quantities for the checks below, from wider signed arithmetic
  logic [W-1:0] chk_diff;
  logic [W:0]   chk_ssum;
  logic [W:0]   chk_sdiff;
  assign chk_diff  = op_a - op_b;
  assign chk_ssum  = {op_a[W-1], op_a} + {op_b[W-1], op_b};
  assign chk_sdiff = {op_a[W-1], op_a} - {op_b[W-1], op_b};

  always_comb begin
    if (op_sel == OP_SUB) begin
      p_sub_diff_r2: assert (res == chk_diff) else $error("R2 subtract result mismatch");
      p_sub_ovf_r4: assert (ovf == (chk_sdiff[W] != chk_sdiff[W-1])) else $error("R4 subtract overflow mismatch");
    end
    if (op_sel == OP_ADD) begin
      p_add_ovf_r3: assert (ovf == (chk_ssum[W] != chk_ssum[W-1])) else $error("R3 add overflow mismatch");
    end
    if (op_sel == OP_NEG && op_a == '0) begin
      p_neg_zero_r5: assert (res == '0 && carry_out && !ovf) else $error("R5 negate zero mismatch");
    end
    if (op_sel == OP_NEG && op_a == MOST_NEG) begin
      p_neg_min_r6: assert (res == MOST_NEG && ovf) else $error("R6 most-negative negate mismatch");
    end
    if (op_sel == OP_EXT) begin
      p_ext_fill_r7: assert (res_wide == {{W{op_a[W-1]}}, op_a} && !ovf && !carry_out) else $error("R7 sign-extend mismatch");
    end
    p_wide_sext_r9: assert (res_wide[2*W-1:W] == {W{res_wide[W-1]}}) else $error("R9 wide output not sign-extended");
  end

endmodule

// File: tb/test_twos_arith_unit.sv
module test_twos_arith_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  a8, b8;  logic [1:0] s8;
  logic [7:0]  r8;      logic [15:0] w8; logic c8, v8;
  logic [3:0]  a4, b4;  logic [1:0] s4;
  logic [3:0]  r4;      logic [7:0]  w4; logic c4, v4;

  twos_arith_unit #(.W(8)) i_twos_arith_unit (
    .op_a(a8), .op_b(b8), .op_sel(s8),
    .res(r8), .res_wide(w8), .carry_out(c8), .ovf(v8));

  twos_arith_unit #(.W(4)) i_twos_arith_unit_w4 (
    .op_a(a4), .op_b(b4), .op_sel(s4),
    .res(r4), .res_wide(w4), .carry_out(c4), .ovf(v4));

  typedef struct {
    bit narrow;
    int op;
    int a, b;
    int res, wide, co, ov;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic exp_t model(bit narrow, int a, int b, int op);
    exp_t e;
    int w    = narrow ? 4 : 8;
    int mask = (1 << w) - 1;
    int s;
    e.narrow = narrow; e.op = op; e.a = a; e.b = b;
    case (op)
      0: s = a + b;                      // R1 add
      1: s = a + ((~b) & mask) + 1;      // R2 subtract
      2: s = ((~a) & mask) + 1;          // R5 negate
      default: s = a;                    // R7 sign-extend
    endcase
    e.res = s & mask;
    e.co  = (op == 3) ? 0 : ((s >> w) & 1);   // R8
    case (op)
      0: e.ov = (((a >> (w-1)) & 1) == ((b >> (w-1)) & 1)) &&
                (((e.res >> (w-1)) & 1) != ((a >> (w-1)) & 1));
      1: e.ov = (((a >> (w-1)) & 1) != ((b >> (w-1)) & 1)) &&
                (((e.res >> (w-1)) & 1) != ((a >> (w-1)) & 1));
      2: e.ov = (a == (1 << (w-1)));     // R6
      default: e.ov = 0;
    endcase
    e.wide = ((e.res >> (w-1)) & 1) ? (e.res | (mask << w)) : e.res;  // R9
    return e;
  endfunction

  task automatic drive(bit narrow, int a, int b, int op);
    @(posedge clk);
    #2;
    if (narrow) begin a4 = a[3:0]; b4 = b[3:0]; s4 = op[1:0]; end
    else        begin a8 = a[7:0]; b8 = b[7:0]; s8 = op[1:0]; end
    sb_q.push_back(model(narrow, a, b, op));
  endtask

  task automatic check(string req, int got, int exp, exp_t e);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s w=%0d op=%0d a=%0h b=%0h actual=%0h expected=%0h",
               req, e.narrow ? 4 : 8, e.op, e.a, e.b, got, exp);
    end
  endtask

  function automatic string res_tag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic string ovf_tag(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // monitor: compare each queued expectation half a cycle after it is driven
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      if (e.narrow) begin
        check(res_tag(e.op), int'(r4), e.res, e);
        check(ovf_tag(e.op), int'(v4), e.ov, e);
        check("R8", int'(c4), e.co, e);
        check("R9", int'(w4), e.wide, e);
      end else begin
        check(res_tag(e.op), int'(r8), e.res, e);
        check(ovf_tag(e.op), int'(v8), e.ov, e);
        check("R8", int'(c8), e.co, e);
        check("R9", int'(w8), e.wide, e);
      end
    end
  end

  initial begin
    a8 = '0; b8 = '0; s8 = '0;
    a4 = '0; b4 = '0; s4 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands, add
    drive(0, 0, 0, 0);
    // R1/R3 add corners
    drive(0, 8'h7f, 8'h01, 0);
    drive(0, 8'h80, 8'hff, 0);
    drive(0, 8'hff, 8'h01, 0);
    drive(0, 8'h64, 8'h1c, 0);
    // R2/R4 subtract corners
    drive(0, 8'h05, 8'h03, 1);
    drive(0, 8'h03, 8'h05, 1);
    drive(0, 8'h80, 8'h01, 1);
    drive(0, 8'h7f, 8'hff, 1);
    drive(0, 8'h00, 8'h00, 1);
    // R5/R6 negate corners
    drive(0, 8'h00, 8'h5a, 2);
    drive(0, 8'h80, 8'h00, 2);
    drive(0, 8'h01, 8'h00, 2);
    drive(0, 8'h7f, 8'h00, 2);
    drive(0, 8'hff, 8'h00, 2);
    // R7 sign-extend corners
    drive(0, 8'h12, 8'hff, 3);
    drive(0, 8'hee, 8'h00, 3);
    drive(0, 8'h80, 8'h00, 3);
    drive(0, 8'h7f, 8'h00, 3);
    // random 8-bit vectors
    for (int i = 0; i < 4000; i++)
      drive(0, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 3));
    // exhaustive 4-bit sweep
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(1, a, b, op);
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule